// File: doc/BRIEF.md
# Instruction-Byte Serial Register Port

This block is a slave serial port that gives a host access to the register bank of a data converter. The port runs only with an external clock: the host supplies SCLK, and the block oversamples SCLK, the active-low chip select and the data line on its own system clock. Each communication cycle has two phases. The host first sends an instruction byte. That byte selects read or write, a byte count of one to three, and a starting register address. The data bytes follow. The address advances by one after each byte.

Write data always enters on the bidirectional SDIO line. Read data leaves on SDIO in 2-wire mode, or on the separate SDO line in 3-wire mode. The control register selects the mode and the data bit order. A converter word arrives on a parallel input and is stored in a three-byte data output register. An active-low data-ready flag is raised when a word arrives and is cleared once the last byte of that register has been read.

Top module: `regport_top`

## Requirements
- R1: The instruction byte always travels MSB-first, with each bit sampled on a rising SCLK edge. Bit 7 selects the direction, where 1 means write and 0 means read. Bits 6:5 hold the byte count minus one. Bits 3:0 hold the start address. Bit 4 is ignored.
- R2: A write stores each data byte at the current address, and the address then increments, wrapping from 15 to 0. Writable bytes are the control register at addresses 4, 5 and 6 and the offset register at addresses 8, 9 and 10. Address 4 maps to bits 7:0 of ctrl_o and address 8 maps to bits 7:0 of offs_o. Writes to any other address change nothing.
- R3: A read returns the content of the addressed byte. Each bit changes only after a falling SCLK edge, so it is stable at the following rising edge. Addresses 0, 1 and 2 return data-word bits 23:16, 15:8 and 7:0. Addresses 4 to 6 and 8 to 10 return the register bytes. All other addresses read as 0.
- R4: Bit 0 of control byte 4 selects the data-byte bit order, with 0 for MSB-first and 1 for LSB-first. The setting applies to both reads and writes, takes effect from the next data byte, and never changes the instruction byte.
- R5: Bit 1 of control byte 4 selects the wiring, with 0 for 2-wire and 1 for 3-wire. In 2-wire mode sdio_oe is high only during the data phase of a read. In 3-wire mode sdio_oe stays low, read bits appear on sdo_o, and write data still enters on sdio_i. sdo_o is 0 whenever no 3-wire read is in progress.
- R6: Raising cs_n_i in the middle of a cycle abandons it. A partly received byte is not written, and the next cycle starts with an instruction byte. When cs_n_i is held low, consecutive cycles follow one another without any break.
- R7: A one-cycle pulse on conv_valid_i stores conv_data_i into the data output register and drives drdy_n_o low. drdy_n_o returns high after the byte at address 2 has been read completely. If a new word arrives in the same clock as that clear, the flag stays low.
- R8: After reset, ctrl_o is 24'h500000. This means MSB-first order, 2-wire mode, gain code 0 (gain of 1), bipolar range, offset-binary coding, and notch code 8'h50. After reset offs_o is 0, drdy_n_o is high and sdio_oe is low.
- R9: A count field of 3 transfers three bytes, the same as a count field of 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk_i | input | 1 | Host serial clock, idle high |
| cs_n_i | input | 1 | Active-low chip select |
| sdio_i | input | 1 | Value seen on the bidirectional data line |
| sdio_o | output | 1 | Read bit driven onto the bidirectional line |
| sdio_oe | output | 1 | Drive enable for the bidirectional line |
| sdo_o | output | 1 | Read data in 3-wire mode |
| conv_data_i | input | 24 | Converter result word |
| conv_valid_i | input | 1 | One-cycle strobe for a new result word |
| drdy_n_o | output | 1 | Active-low data-ready flag |
| ctrl_o | output | 24 | Control register contents |
| offs_o | output | 24 | Offset register contents |

## Verification
If the bit counter or the phase state is wrong, every later byte of the transfer shifts by whole bits. The error shows in the very next read-back and on ctrl_o or offs_o as soon as a write completes. A wrong bit-order or wiring bit in the control register shows within one byte: sdio_oe rises during a 3-wire read, or the read byte comes back bit-reversed. The sweep writes and reads back every start address with every byte count, including cycles that change the mode partway through. An error in the data-ready logic shows on drdy_n_o within a few clocks after the third data byte has been read, or after a partial read that must leave the flag low.

// File: rtl/regport_pkg.sv
// Package for the serial register port.
// Holds the phase type and the register address constants.
// Assumes byte-wide registers and a 4-bit address space.
package regport_pkg;

    typedef enum logic {
        PH_INSTR = 1'b0,
        PH_DATA  = 1'b1
    } phase_e;

    localparam int ADDR_W = 4;
    localparam int BYTE_W = 8;
    localparam int LANES  = 3;

    localparam logic [ADDR_W-1:0] A_DAT0 = 4'd0;
    localparam logic [ADDR_W-1:0] A_DAT2 = 4'd2;
    localparam logic [ADDR_W-1:0] A_CTL0 = 4'd4;
    localparam logic [ADDR_W-1:0] A_CTL2 = 4'd6;
    localparam logic [ADDR_W-1:0] A_OFS0 = 4'd8;
    localparam logic [ADDR_W-1:0] A_OFS2 = 4'd10;

    // Bit positions inside control byte 0.
    localparam int CB_LSB_FIRST = 0;
    localparam int CB_THREE_WIRE = 1;

endpackage

// File: rtl/regport_sync.sv
// Input synchronizer and SCLK edge detector.
// Sends SCLK, chip select and the data line through STAGES flops each,
// then flags the rising and falling edges of the synchronized SCLK.
// Assumes STAGES >= 2 and an SCLK half period of several system clocks.
module regport_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    input  logic cs_n_i,
    input  logic sdio_i,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_n_s,
    output logic din_s
);
    localparam int NSIG = 3;
    localparam logic [NSIG-1:0] RST_VAL = 3'b110;

    logic [NSIG-1:0] raw;
    logic [NSIG-1:0] stage [STAGES];
    logic            sclk_prev;

    assign raw = {sclk_i, cs_n_i, sdio_i};

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // First flop of the chain captures the raw pins.
            always_ff @(posedge clk) begin
                if (!rst_n) stage[s] <= RST_VAL;
                else        stage[s] <= raw;
            end
        end else begin : g_next
            // Each later flop re-samples the previous stage.
            always_ff @(posedge clk) begin
                if (!rst_n) stage[s] <= RST_VAL;
                else        stage[s] <= stage[s-1];
            end
        end
    end

    // Hold the previous synchronized SCLK for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_prev <= 1'b1;
        else        sclk_prev <= stage[STAGES-1][2];
    end

    assign sclk_rise = stage[STAGES-1][2] & ~sclk_prev;
    assign sclk_fall = ~stage[STAGES-1][2] & sclk_prev;
    assign cs_n_s    = stage[STAGES-1][1];
    assign din_s     = stage[STAGES-1][0];

endmodule

// File: rtl/regport_shifter.sv
// Protocol engine of the serial register port.
// Receives the instruction byte, then moves data bytes to or from the register bank.
// Write bits are sampled on rising SCLK edges; read bits are launched on falling edges.
// Assumes its edge strobes last one cycle and that cs_n_s is synchronized.
module regport_shifter
    import regport_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise,
    input  logic              fall,
    input  logic              cs_n_s,
    input  logic              din,
    input  logic              lsb_first,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              wr_en,
    output logic [BYTE_W-1:0] wr_data,
    output logic              rd_done,
    output logic              rd_active,
    output logic              tx_bit
);
    phase_e            phase;
    logic [2:0]        cnt;
    logic [BYTE_W-1:0] sh;
    logic [BYTE_W-1:0] txb;
    logic [BYTE_W-1:0] rx_next;
    logic [BYTE_W-1:0] tx_cur;
    logic              is_wr;
    logic [1:0]        left;
    logic              byte_end;

    // Next shift value; data bytes follow the bit order, the instruction is always MSB-first.
    assign rx_next  = (phase == PH_DATA && lsb_first) ? {din, sh[BYTE_W-1:1]}
                                                      : {sh[BYTE_W-2:0], din};
    assign byte_end = rise && !cs_n_s && (cnt == 3'd7);
    assign wr_en    = byte_end && (phase == PH_DATA) && is_wr;
    assign rd_done  = byte_end && (phase == PH_DATA) && !is_wr;
    assign wr_data  = rx_next;
    assign rd_active = (phase == PH_DATA) && !is_wr && !cs_n_s;
    assign tx_cur   = (cnt == 3'd0) ? rd_data : txb;

    // Shift input, count bits, decode the instruction and walk the address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_INSTR;
            cnt      <= 3'd0;
            sh       <= '0;
            is_wr    <= 1'b0;
            left     <= 2'd0;
            cur_addr <= '0;
        end else if (cs_n_s) begin
            phase <= PH_INSTR;
            cnt   <= 3'd0;
        end else if (rise) begin
            sh  <= rx_next;
            cnt <= cnt + 3'd1;
            if (cnt == 3'd7) begin
                if (phase == PH_INSTR) begin
                    is_wr    <= rx_next[7];
                    left     <= (rx_next[6:5] == 2'd3) ? 2'd2 : rx_next[6:5];
                    cur_addr <= rx_next[ADDR_W-1:0];
                    phase    <= PH_DATA;
                end else begin
                    cur_addr <= cur_addr + 1'b1;
                    if (left == 2'd0) phase <= PH_INSTR;
                    else              left  <= left - 2'd1;
                end
            end
        end
    end

    // Launch read bits on falling edges; the byte is fetched at its first bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txb    <= '0;
            tx_bit <= 1'b0;
        end else if (fall && !cs_n_s && phase == PH_DATA && !is_wr) begin
            if (cnt == 3'd0) txb <= rd_data;
            tx_bit <= lsb_first ? tx_cur[cnt] : tx_cur[3'd7 - cnt];
        end
    end

    // R1
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rise && !cs_n_s) |=> $stable(cnt));

    // R3
    tx_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fall |=> $stable(tx_bit));

endmodule

// File: rtl/regport_regfile.sv
// Register bank of the serial register port.
// Holds the data output word, the control register and the offset register,
// and keeps the active-low data-ready flag.
// Assumes at most one write per clock and byte-wide access.
module regport_regfile
    import regport_pkg::*;
#(
    parameter int          DATA_W    = 24,
    parameter logic [7:0]  NOTCH_DEF = 8'h50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              rd_done,
    output logic [BYTE_W-1:0] rd_data,
    input  logic [DATA_W-1:0] conv_data,
    input  logic              conv_valid,
    output logic              lsb_first,
    output logic              three_wire,
    output logic              drdy_n,
    output logic [DATA_W-1:0] ctrl,
    output logic [DATA_W-1:0] offs
);
    localparam int NB = DATA_W / BYTE_W;
    localparam logic [DATA_W-1:0] CTL_DEF = {NOTCH_DEF, {(DATA_W-BYTE_W){1'b0}}};

    logic [DATA_W-1:0] dat_q;
    logic [DATA_W-1:0] ctl_q;
    logic [DATA_W-1:0] ofs_q;
    logic [ADDR_W-1:0] ctl_idx;
    logic [ADDR_W-1:0] ofs_idx;
    logic [ADDR_W-1:0] dat_idx;

    assign ctl_idx = addr - A_CTL0;
    assign ofs_idx = addr - A_OFS0;
    assign dat_idx = A_DAT2 - addr;

    // Store byte writes into the control and offset lanes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= CTL_DEF;
            ofs_q <= '0;
        end else if (wr_en) begin
            for (int b = 0; b < NB; b++) begin
                if (ctl_idx == ADDR_W'(b)) ctl_q[b*BYTE_W +: BYTE_W] <= wr_data;
                if (ofs_idx == ADDR_W'(b)) ofs_q[b*BYTE_W +: BYTE_W] <= wr_data;
            end
        end
    end

    // Capture each converter word and manage the data-ready flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dat_q  <= '0;
            drdy_n <= 1'b1;
        end else if (conv_valid) begin
            dat_q  <= conv_data;
            drdy_n <= 1'b0;
        end else if (rd_done && addr == A_DAT2) begin
            drdy_n <= 1'b1;
        end
    end

    // Read mux: data word is high byte first, register lanes are low byte first.
    always_comb begin
        rd_data = '0;
        for (int b = 0; b < NB; b++) begin
            if (ctl_idx == ADDR_W'(b)) rd_data = ctl_q[b*BYTE_W +: BYTE_W];
            if (ofs_idx == ADDR_W'(b)) rd_data = ofs_q[b*BYTE_W +: BYTE_W];
            if (dat_idx == ADDR_W'(b)) rd_data = dat_q[b*BYTE_W +: BYTE_W];
        end
    end

    assign lsb_first  = ctl_q[CB_LSB_FIRST];
    assign three_wire = ctl_q[CB_THREE_WIRE];
    assign ctrl       = ctl_q;
    assign offs       = ofs_q;

    // R8
    reset_default_chk: assert property (@(posedge clk)
        !rst_n |=> (ctl_q == CTL_DEF && ofs_q == '0 && drdy_n));

    // R7
    drdy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_valid |=> !drdy_n);

    // R7
    drdy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done && addr == A_DAT2 && !conv_valid) |=> drdy_n);

endmodule

// File: rtl/regport_top.sv
// Top level of the instruction-byte serial register port.
// Connects the synchronizer, the protocol engine and the register bank,
// and steers read data to SDIO (2-wire) or SDO (3-wire).
// Assumes SCLK is an input from the host with a half period of at least four clocks.
module regport_top
    import regport_pkg::*;
#(
    parameter int         DATA_W      = 24,
    parameter int         SYNC_STAGES = 2,
    parameter logic [7:0] NOTCH_DEF   = 8'h50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_i,
    input  logic              cs_n_i,
    input  logic              sdio_i,
    output logic              sdio_o,
    output logic              sdio_oe,
    output logic              sdo_o,
    input  logic [DATA_W-1:0] conv_data_i,
    input  logic              conv_valid_i,
    output logic              drdy_n_o,
    output logic [DATA_W-1:0] ctrl_o,
    output logic [DATA_W-1:0] offs_o
);
    logic              rise;
    logic              fall;
    logic              cs_n_s;
    logic              din_s;
    logic              lsb_first;
    logic              three_wire;
    logic [BYTE_W-1:0] rd_data;
    logic [ADDR_W-1:0] cur_addr;
    logic              wr_en;
    logic [BYTE_W-1:0] wr_data;
    logic              rd_done;
    logic              rd_active;
    logic              tx_bit;

    regport_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_i    (sclk_i),
        .cs_n_i    (cs_n_i),
        .sdio_i    (sdio_i),
        .sclk_rise (rise),
        .sclk_fall (fall),
        .cs_n_s    (cs_n_s),
        .din_s     (din_s)
    );

    regport_shifter shift_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise      (rise),
        .fall      (fall),
        .cs_n_s    (cs_n_s),
        .din       (din_s),
        .lsb_first (lsb_first),
        .rd_data   (rd_data),
        .cur_addr  (cur_addr),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_done   (rd_done),
        .rd_active (rd_active),
        .tx_bit    (tx_bit)
    );

    regport_regfile #(.DATA_W(DATA_W), .NOTCH_DEF(NOTCH_DEF)) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .addr       (cur_addr),
        .wr_data    (wr_data),
        .rd_done    (rd_done),
        .rd_data    (rd_data),
        .conv_data  (conv_data_i),
        .conv_valid (conv_valid_i),
        .lsb_first  (lsb_first),
        .three_wire (three_wire),
        .drdy_n     (drdy_n_o),
        .ctrl       (ctrl_o),
        .offs       (offs_o)
    );

    // Pin steering for read data.
    assign sdio_o  = tx_bit;
    assign sdio_oe = rd_active && !three_wire;
    assign sdo_o   = rd_active && three_wire && tx_bit;

    // R5
    no_write_in_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sdio_oe |-> !wr_en);

endmodule

// File: tb/regport_top_tb_top.sv
// Bench for regport_top: sweeps all start addresses and byte counts,
// models the register bank in the bench, and runs directed cases for abort,
// tied-low chip select, the count-field clamp and data-ready.
module regport_top_tb_top;
    localparam int HB = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b1;
    logic        cs_n = 1'b1;
    logic        host_v = 1'b0;
    logic        sdio_line;
    logic        sdio_o, sdio_oe, sdo_o, drdy_n;
    logic [23:0] conv_data = '0;
    logic        conv_valid = 1'b0;
    logic [23:0] ctrl, offs;

    int checks = 0;
    int fails = 0;
    logic [7:0]  mem [16];
    logic [23:0] conv_m = '0;

    always #5 clk = ~clk;

    assign sdio_line = sdio_oe ? sdio_o : host_v;

    regport_top dut_i (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .cs_n_i(cs_n), .sdio_i(sdio_line),
        .sdio_o(sdio_o), .sdio_oe(sdio_oe), .sdo_o(sdo_o),
        .conv_data_i(conv_data), .conv_valid_i(conv_valid), .drdy_n_o(drdy_n),
        .ctrl_o(ctrl), .offs_o(offs)
    );

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic writable(input int a);
        return (a >= 4 && a <= 6) || (a >= 8 && a <= 10);
    endfunction

    function automatic logic [7:0] exp_rd(input int a);
        if (a <= 2) return conv_m[(2-a)*8 +: 8];
        if (writable(a)) return mem[a];
        return 8'h00;
    endfunction

    // One SCLK period: fall, drive, sample just before the rise, rise.
    task automatic bit_x(input logic v, output logic r, output logic oe);
        sclk = 1'b0;
        host_v = v;
        repeat (HB) @(negedge clk);
        r  = mem[4][1] ? sdo_o : sdio_line;
        oe = sdio_oe;
        sclk = 1'b1;
        repeat (HB) @(negedge clk);
    endtask

    task automatic send_instr(input logic [7:0] ins);
        logic r, oe;
        for (int i = 7; i >= 0; i--) bit_x(ins[i], r, oe);
    endtask

    task automatic data_byte(input logic rd, input logic [7:0] wv, output logic [7:0] rv, output logic oe_ok);
        logic r, oe;
        logic lsb;
        lsb = mem[4][0];
        oe_ok = 1'b1;
        rv = '0;
        for (int i = 0; i < 8; i++) begin
            int idx;
            idx = lsb ? i : 7 - i;
            bit_x(rd ? 1'b0 : wv[idx], r, oe);
            rv[idx] = r;
            if (oe !== (rd && !mem[4][1])) oe_ok = 1'b0;
        end
    endtask

    task automatic cs_on();
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic cs_off();
        repeat (4) @(negedge clk);
        cs_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    // R2 R4: write n bytes from address a, updating the bench model per byte.
    task automatic do_write(input int a, input int n, input logic [23:0] d, input logic keep_cs);
        logic [7:0] rv;
        logic ok;
        if (!keep_cs) cs_on();
        send_instr({1'b1, 2'(n-1), 1'b0, 4'(a)});
        for (int k = 0; k < n; k++) begin
            int ad;
            ad = (a + k) % 16;
            data_byte(1'b0, d[k*8 +: 8], rv, ok);
            chk(ok, "R5 oe during write", 32'(ok), 32'd1);
            if (writable(ad)) mem[ad] = d[k*8 +: 8];
        end
        if (!keep_cs) cs_off();
    endtask

    // R3 R5: read n bytes from address a and compare with the model.
    task automatic do_read(input int a, input int n, input logic keep_cs, input string req);
        logic [7:0] rv;
        logic ok;
        if (!keep_cs) cs_on();
        send_instr({1'b0, 2'(n-1), 1'b0, 4'(a)});
        for (int k = 0; k < n; k++) begin
            int ad;
            ad = (a + k) % 16;
            data_byte(1'b1, 8'h00, rv, ok);
            chk(rv == exp_rd(ad), req, 32'(rv), 32'(exp_rd(ad)));
            chk(ok, "R5 oe during read", 32'(ok), 32'd1);
        end
        if (!keep_cs) cs_off();
    endtask

    task automatic chk_regs(input string req);
        chk(ctrl == {mem[6], mem[5], mem[4]}, req, 32'(ctrl), 32'({mem[6], mem[5], mem[4]}));
        chk(offs == {mem[10], mem[9], mem[8]}, req, 32'(offs), 32'({mem[10], mem[9], mem[8]}));
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        for (int i = 0; i < 16; i++) mem[i] = 8'h00;
        mem[6] = 8'h50;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R8 reset state
        chk(ctrl == 24'h500000, "R8 ctrl", 32'(ctrl), 32'h500000);
        chk(offs == 24'h0, "R8 offs", 32'(offs), 32'h0);
        chk(drdy_n == 1'b1, "R8 drdy", 32'(drdy_n), 32'h1);
        chk(sdio_oe == 1'b0, "R8 oe", 32'(sdio_oe), 32'h0);
        do_read(4, 3, 1'b0, "R8 readback");

        // R1 R2 R3 R4 R5: every start address with every count
        for (int a = 0; a < 16; a++) begin
            for (int n = 1; n <= 3; n++) begin
                logic [23:0] d;
                for (int k = 0; k < 3; k++) d[k*8 +: 8] = 8'((a*37 + n*11 + k*53 + 7));
                do_write(a, n, d, 1'b0);
                chk_regs("R2 write");
                do_read(a, n, 1'b0, "R3 sweep read");
            end
        end

        // Back to MSB-first, 2-wire
        do_write(4, 1, 24'h0, 1'b0);
        chk_regs("R2 ctrl restore");

        // R4 LSB-first write and read, checked at the ports
        do_write(4, 1, 24'h01, 1'b0);
        do_write(8, 1, 24'h0F, 1'b0);
        chk(offs[7:0] == 8'h0F, "R4 lsb-first write", 32'(offs[7:0]), 32'h0F);
        do_read(8, 1, 1'b0, "R4 lsb-first read");
        // R5 3-wire with LSB-first
        do_write(4, 1, 24'h03, 1'b0);
        do_write(9, 2, 24'hC35A, 1'b0);
        chk_regs("R5 3-wire write");
        do_read(9, 2, 1'b0, "R5 3-wire read");
        do_write(4, 1, 24'h00, 1'b0);
        chk_regs("R4 restore");

        // R9 count field 3 behaves as three bytes; bit 4 ignored
        cs_on();
        send_instr(8'b1_11_1_1000);
        for (int k = 0; k < 3; k++) begin
            logic [7:0] rv;
            logic ok;
            data_byte(1'b0, 8'(8'h21 + k), rv, ok);
            mem[8 + k] = 8'(8'h21 + k);
        end
        cs_off();
        chk(offs == 24'h232221, "R9 count clamp", 32'(offs), 32'h232221);
        do_read(8, 3, 1'b0, "R9 readback");

        // R6 abort mid-byte leaves the register unchanged
        cs_on();
        send_instr({1'b1, 2'd0, 1'b0, 4'd9});
        for (int i = 0; i < 4; i++) begin
            logic r, oe;
            bit_x(1'b1, r, oe);
        end
        cs_off();
        chk(offs == 24'h232221, "R6 abort", 32'(offs), 32'h232221);
        do_read(9, 1, 1'b0, "R6 after abort");

        // R6 chip select held low for back-to-back cycles
        cs_on();
        do_write(10, 1, 24'h77, 1'b1);
        do_read(10, 1, 1'b1, "R6 tied low read");
        do_write(8, 2, 24'hBEEF, 1'b1);
        do_read(8, 3, 1'b1, "R6 tied low read 2");
        cs_off();
        chk_regs("R6 tied low");

        // R7 data ready: partial read keeps it low, address 2 clears it
        conv_data = 24'hA5C3E1;
        conv_valid = 1'b1;
        @(negedge clk);
        conv_valid = 1'b0;
        conv_m = 24'hA5C3E1;
        @(negedge clk);
        chk(drdy_n == 1'b0, "R7 set", 32'(drdy_n), 32'h0);
        do_read(0, 2, 1'b0, "R7 word read");
        chk(drdy_n == 1'b0, "R7 partial read", 32'(drdy_n), 32'h0);
        do_read(2, 1, 1'b0, "R7 last byte");
        chk(drdy_n == 1'b1, "R7 clear", 32'(drdy_n), 32'h1);
        conv_data = 24'h13579B;
        conv_valid = 1'b1;
        @(negedge clk);
        conv_valid = 1'b0;
        conv_m = 24'h13579B;
        @(negedge clk);
        chk(drdy_n == 1'b0, "R7 set again", 32'(drdy_n), 32'h0);
        do_write(0, 3, 24'hFFFFFF, 1'b0);
        chk(drdy_n == 1'b0, "R7 write no clear", 32'(drdy_n), 32'h0);
        do_read(0, 3, 1'b0, "R7 full read");
        chk(drdy_n == 1'b1, "R7 clear full", 32'(drdy_n), 32'h1);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule